// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial PHY out of reset after a single start pulse and reports when the PHY's receive PLL has locked. It first turns on the PHY reference PLL clock and waits a settling interval. It then uses an indirect register path to reach the PHY. The path takes an address access, then a data access, through a handshake master that sits below this block. Over that path the block sets the reset bit of the PHY clock/reset register. It then polls the lane status register until the receive-PLL state flag reads as one.

Each command is placed on a small command port as an operation code plus a 16-bit value. The handshake master completes each command with a one-cycle done pulse, which can carry an error flag and, for reads, the returned data. The block allows a bounded number of poll iterations. The run ends in one of three ways: ready after a final delay, a timeout fault, or an access fault taken from the handshake master. After any fault the PLL clock is switched off. A later start pulse reruns the whole sequence.

Top module: `phy_rst_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, `pll_clk_en`, `cmd_valid`, `phy_ready` and `seq_err` are 0 and `err_code` is 0. An asserted reset clears all of them at once, even in the middle of a run.
- R2: A start pulse taken in the idle, ready or fault state raises `pll_clk_en` on the next cycle. The first command appears SETTLE_CYC cycles after the edge that captured start.
- R3: Commands come in a fixed order. First an address command (op 2'b00) with value 0x7F3F. Then a write command (op 2'b01) with value 0x0001, which sets reset bit 0. Then pairs of an address command with value 0x2003 and a read command (op 2'b10). The value of a read command carries no meaning.
- R4: A command completes on a clock edge where `cmd_valid` and `rsp_done` are both 1. Until that edge, `cmd_valid`, `cmd_op` and `cmd_data` hold steady.
- R5: Before every poll address command, the block waits a delay. Counted from the edge that completes the reset write or the previous read, the address command appears POLL_CYC cycles later.
- R6: Only bit 1 of `rsp_data` on a completed read decides lock. A read returning 0xFFFD (every bit except bit 1 set) counts as not locked.
- R7: If MAX_POLLS reads complete without the lock flag, the sequence stops with no further command. It then raises `seq_err` with `err_code` 2'b01 and drops `pll_clk_en`. A lock seen on read MAX_POLLS still gives ready.
- R8: A completion with `rsp_err` set ends the sequence at once. This holds for every command, including a read whose data has the lock flag set. The block then raises `seq_err` with `err_code` 2'b10 and drops `pll_clk_en`.
- R9: `phy_ready` rises FINAL_CYC cycles after the edge that completes the locking read. It then stays 1, with `pll_clk_en` 1 and no commands issued, until the next start. `phy_ready` and `seq_err` are never 1 together.
- R10: A start pulse while the sequence is running has no effect on the command stream or on the outcome. A start taken from the ready or fault state clears both status outputs on the next cycle and reruns the sequence from the PLL enable step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| start | input | 1 | One-cycle request to run the sequence |
| pll_clk_en | output | 1 | Enable for the PHY reference PLL clock |
| cmd_valid | output | 1 | Command pending for the handshake master |
| cmd_op | output | 2 | Operation: 00 address, 01 write, 10 read |
| cmd_data | output | DATA_W | Register address or write value |
| rsp_done | input | 1 | One-cycle completion of the pending command |
| rsp_err | input | 1 | Completion carries an access error |
| rsp_data | input | DATA_W | Read data, valid with a read completion |
| phy_ready | output | 1 | PHY receive PLL locked; sequence finished |
| seq_err | output | 1 | Sequence ended in a fault |
| err_code | output | 2 | Fault cause: 01 lock timeout, 10 access error |

## Verification
A wrong state register shows up at the command port within one cycle. The port then shows a command out of order, a command with the wrong value, or a missing command, and the bench checks every command against the required order. A delay counter that is off by one moves the first command, every poll address or the ready edge by a cycle, and the bench measures each of these against the edge that triggered it. A poll counter that drifts shows up at the end of the run as the wrong number of reads before the timeout, or as a run that times out early.

// File: rtl/phy_rst_seq_pkg.sv
`timescale 1ns/1ps
package phy_rst_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_RST_ADDR,
    ST_RST_WR,
    ST_POLL_WAIT,
    ST_POLL_ADDR,
    ST_POLL_RD,
    ST_FINAL,
    ST_READY,
    ST_FAIL
  } seq_state_e;

  localparam logic [1:0] OP_ADDR  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam logic [1:0] FC_NONE    = 2'b00;
  localparam logic [1:0] FC_TIMEOUT = 2'b01;
  localparam logic [1:0] FC_ACCESS  = 2'b10;

  function automatic logic is_cmd_state(seq_state_e s);
    return (s == ST_RST_ADDR) || (s == ST_RST_WR) ||
           (s == ST_POLL_ADDR) || (s == ST_POLL_RD);
  endfunction

endpackage

// File: rtl/prs_delay_timer.sv
`timescale 1ns/1ps
module prs_delay_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R5: a running delay advances by exactly one each cycle
  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/prs_poll_counter.sv
`timescale 1ns/1ps
module prs_poll_counter #(
  parameter int MAX_POLLS = 10,
  localparam int PW = $clog2(MAX_POLLS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == PW'(MAX_POLLS - 1));

  // R7: reads never pass the iteration budget
  p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (cnt_q < PW'(MAX_POLLS)));

endmodule

// File: rtl/prs_cmd_drv.sv
`timescale 1ns/1ps
module prs_cmd_drv
  import phy_rst_seq_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter logic [DATA_W-1:0] RST_ADDR = 16'h7F3F,
  parameter logic [DATA_W-1:0] STA_ADDR = 16'h2003,
  parameter int              RST_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        nxt_state,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [DATA_W-1:0] cmd_data
);

  localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(1) << RST_BIT;

  logic              valid_d, ld_en;
  logic [1:0]        op_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    valid_d = is_cmd_state(nxt_state);
    ld_en   = valid_d;
    op_d    = OP_ADDR;
    data_d  = STA_ADDR;
    case (nxt_state)
      ST_RST_ADDR:  begin op_d = OP_ADDR;  data_d = RST_ADDR; end
      ST_RST_WR:    begin op_d = OP_WRITE; data_d = RST_VAL;  end
      ST_POLL_ADDR: begin op_d = OP_ADDR;  data_d = STA_ADDR; end
      ST_POLL_RD:   begin op_d = OP_READ;  data_d = STA_ADDR; end
      default:      begin op_d = OP_ADDR;  data_d = STA_ADDR; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_valid <= 1'b0;
    else        cmd_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_op   <= OP_ADDR;
      cmd_data <= '0;
    end else if (ld_en) begin
      cmd_op   <= op_d;
      cmd_data <= data_d;
    end
  end

endmodule

// File: rtl/phy_rst_seq.sv
`timescale 1ns/1ps
module phy_rst_seq
  import phy_rst_seq_pkg::*;
#(
  parameter int                DATA_W     = 16,
  parameter int                SETTLE_CYC = 25000,
  parameter int                POLL_CYC   = 25000,
  parameter int                FINAL_CYC  = 250000,
  parameter int                MAX_POLLS  = 10,
  parameter logic [DATA_W-1:0] RST_ADDR   = 16'h7F3F,
  parameter int                RST_BIT    = 0,
  parameter logic [DATA_W-1:0] STA_ADDR   = 16'h2003,
  parameter int                LOCK_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              pll_clk_en,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              rsp_done,
  input  logic              rsp_err,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              phy_ready,
  output logic              seq_err,
  output logic [1:0]        err_code
);

  localparam int MAX_DLY = (SETTLE_CYC > POLL_CYC) ?
                           ((SETTLE_CYC > FINAL_CYC) ? SETTLE_CYC : FINAL_CYC) :
                           ((POLL_CYC > FINAL_CYC) ? POLL_CYC : FINAL_CYC);
  localparam int CNT_W = $clog2(MAX_DLY + 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  seq_state_e       state_q, state_d;
  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic             poll_clr, poll_inc, poll_last;
  logic             can_start, done_ok, done_bad, locked;
  logic [1:0]       code_d;
  logic             code_en;
  logic             unused_rsp_bits;

  assign unused_rsp_bits = ^rsp_data;
  assign can_start = start && ((state_q == ST_IDLE) || (state_q == ST_READY) ||
                               (state_q == ST_FAIL));
  assign done_ok   = rsp_done && !rsp_err;
  assign done_bad  = rsp_done &&  rsp_err;
  assign locked    = rsp_data[LOCK_BIT];

  // next-state process
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_READY, ST_FAIL: if (start) state_d = ST_SETTLE;
      ST_SETTLE:    if (tmr_exp) state_d = ST_RST_ADDR;
      ST_RST_ADDR:  if (done_bad) state_d = ST_FAIL;
                    else if (done_ok) state_d = ST_RST_WR;
      ST_RST_WR:    if (done_bad) state_d = ST_FAIL;
                    else if (done_ok) state_d = ST_POLL_WAIT;
      ST_POLL_WAIT: if (tmr_exp) state_d = ST_POLL_ADDR;
      ST_POLL_ADDR: if (done_bad) state_d = ST_FAIL;
                    else if (done_ok) state_d = ST_POLL_RD;
      ST_POLL_RD: begin
        if (done_bad)               state_d = ST_FAIL;
        else if (done_ok && locked) state_d = ST_FINAL;
        else if (done_ok)           state_d = poll_last ? ST_FAIL : ST_POLL_WAIT;
      end
      ST_FINAL:     if (tmr_exp) state_d = ST_READY;
      default:      state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // delay timer load on entry to a waiting state
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state_d != state_q) begin
      case (state_d)
        ST_SETTLE:    begin tmr_load = 1'b1; tmr_val = CNT_W'(SETTLE_CYC - 1); end
        ST_POLL_WAIT: begin tmr_load = 1'b1; tmr_val = CNT_W'(POLL_CYC - 1);   end
        ST_FINAL:     begin tmr_load = 1'b1; tmr_val = CNT_W'(FINAL_CYC - 1);  end
        default:      begin tmr_load = 1'b0; tmr_val = '0;                      end
      endcase
    end
  end

  prs_delay_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  assign poll_clr = can_start;
  assign poll_inc = (state_q == ST_POLL_RD) && done_ok;

  prs_poll_counter #(.MAX_POLLS(MAX_POLLS)) i_polls (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (poll_clr),
    .inc   (poll_inc),
    .last  (poll_last)
  );

  prs_cmd_drv #(
    .DATA_W   (DATA_W),
    .RST_ADDR (RST_ADDR),
    .STA_ADDR (STA_ADDR),
    .RST_BIT  (RST_BIT)
  ) i_cmd (
    .clk       (clk),
    .rst_n     (srst_n),
    .nxt_state (state_d),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data)
  );

  // fault cause register
  always_comb begin
    code_en = 1'b0;
    code_d  = err_code;
    if (can_start) begin
      code_en = 1'b1;
      code_d  = FC_NONE;
    end else if (state_d == ST_FAIL && state_q != ST_FAIL) begin
      code_en = 1'b1;
      code_d  = done_bad ? FC_ACCESS : FC_TIMEOUT;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      err_code <= FC_NONE;
    else if (code_en) err_code <= code_d;
  end

  assign phy_ready  = (state_q == ST_READY);
  assign seq_err    = (state_q == ST_FAIL);
  assign pll_clk_en = (state_q != ST_IDLE) && (state_q != ST_FAIL);

  // R4: a pending command holds until completed
  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_valid && !rsp_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));

  // R2: commands only go out with the PLL clock running
  p_pll_with_cmd_r2: assert property (@(posedge clk) disable iff (!srst_n)
    cmd_valid |-> pll_clk_en);

  // R8: a fault leaves the PLL clock off and no command pending
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!srst_n)
    seq_err |-> (!pll_clk_en && !cmd_valid && err_code != FC_NONE));

  // R9: ready and fault are exclusive, and ready holds until a start
  p_ready_excl_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !(phy_ready && seq_err));
  p_ready_hold_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (phy_ready && !start) |=> (phy_ready && !cmd_valid));

endmodule

// File: tb/test_phy_rst_seq.sv
`timescale 1ns/1ps
module test_phy_rst_seq;

  localparam int S_CYC = 5;
  localparam int W_CYC = 3;
  localparam int F_CYC = 12;
  localparam int NPOLL = 10;
  localparam int NV    = 10;

  typedef struct packed {
    int lat;      // response latency in cycles
    int lock_at;  // read number that returns lock (0 = never)
    int err_at;   // command number answered with error (0 = none)
    int inject;   // pulse start while running
    int x_code;
    int x_reads;
    int x_cmds;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1, 1,  0, 0, 0, 1,  4},
    '{0, 4,  0, 1, 0, 4,  10},
    '{2, 10, 0, 0, 0, 10, 22},
    '{0, 0,  0, 0, 1, 10, 22},
    '{1, 11, 0, 0, 1, 10, 22},
    '{0, 1,  1, 0, 2, 0,  1},
    '{1, 1,  2, 0, 2, 0,  2},
    '{0, 3,  5, 1, 2, 1,  5},
    '{2, 1,  4, 0, 2, 1,  4},
    '{0, 2,  0, 0, 0, 2,  6}
  };

  logic        clk = 1'b0;
  logic        rst_n, start;
  logic        pll_clk_en, cmd_valid, rsp_done, rsp_err, phy_ready, seq_err;
  logic [1:0]  cmd_op, err_code;
  logic [15:0] cmd_data, rsp_data;

  int checks = 0, errors = 0, cyc = 0;
  int lat = 0, lock_at = 0, err_at = 0;
  int ncmd = 0, nread = 0, seq_bad = 0, gap_bad = 0, last_ack = 0, lock_ack = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_rst_seq #(
    .SETTLE_CYC (S_CYC),
    .POLL_CYC   (W_CYC),
    .FINAL_CYC  (F_CYC),
    .MAX_POLLS  (NPOLL)
  ) i_phy_rst_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .pll_clk_en (pll_clk_en),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_data   (cmd_data),
    .rsp_done   (rsp_done),
    .rsp_err    (rsp_err),
    .rsp_data   (rsp_data),
    .phy_ready  (phy_ready),
    .seq_err    (seq_err),
    .err_code   (err_code)
  );

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // handshake master model
  initial begin
    logic [1:0]  op0;
    logic [15:0] d0;
    rsp_done = 1'b0; rsp_err = 1'b0; rsp_data = '0;
    forever begin
      @(negedge clk);
      rsp_done = 1'b0; rsp_err = 1'b0; rsp_data = '0;
      if (rst_n && cmd_valid) begin
        ncmd++;
        op0 = cmd_op; d0 = cmd_data;
        if (ncmd == 1 && !(op0 == 2'b00 && d0 == 16'h7F3F)) seq_bad++;
        if (ncmd == 2 && !(op0 == 2'b01 && d0 == 16'h0001)) seq_bad++;
        if (ncmd > 2 && ncmd % 2 == 1 && !(op0 == 2'b00 && d0 == 16'h2003)) seq_bad++;
        if (ncmd > 2 && ncmd % 2 == 0 && op0 != 2'b10) seq_bad++;
        if (op0 == 2'b00 && d0 == 16'h2003 && (cyc - last_ack) != W_CYC + 1) gap_bad++;
        for (int w = 0; w < lat; w++) begin
          @(negedge clk);
          if (!cmd_valid || cmd_op != op0 || cmd_data != d0) seq_bad++;
        end
        rsp_done = 1'b1;
        rsp_err  = (ncmd == err_at);
        if (op0 == 2'b10) begin
          nread++;
          rsp_data = (nread == lock_at) ? 16'h0002 : 16'hFFFD;
          if (nread == lock_at) lock_ack = cyc;
        end
        last_ack = cyc;
      end
    end
  end

  task automatic run_vec(int k);
    int c0, n;
    vec_t v;
    v = VECS[k];
    lat = v.lat; lock_at = v.lock_at; err_at = v.err_at;
    ncmd = 0; nread = 0; seq_bad = 0; gap_bad = 0; last_ack = 0; lock_ack = 0;
    @(negedge clk);
    start = 1'b1; c0 = cyc;
    @(negedge clk);
    start = 1'b0;
    chk("R2", pll_clk_en, 1, "pll enable after start");
    chk("R10", {30'd0, phy_ready, seq_err}, 0, "status cleared by start");
    n = 0;
    while (!cmd_valid && n < 1000) begin @(negedge clk); n++; end
    chk("R2", cyc - c0, S_CYC + 1, "settle cycles to first command");
    if (v.inject != 0) begin
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!phy_ready && !seq_err && n < 2000) begin @(negedge clk); n++; end
    chk("R3", ncmd, v.x_cmds, "command count");
    chk("R3", seq_bad, 0, "command order, value or hold (R4)");
    chk("R5", gap_bad, 0, "poll delay violations");
    chk("R6", nread, v.x_reads, "reads completed");
    chk("R7", int'(err_code), v.x_code, "fault code (R8)");
    chk("R9", phy_ready, (v.x_code == 0) ? 1 : 0, "ready outcome");
    chk("R8", seq_err, (v.x_code != 0) ? 1 : 0, "fault outcome");
    if (v.x_code == 0) begin
      chk("R9", cyc - lock_ack, F_CYC + 1, "final delay to ready");
      repeat (5) @(negedge clk);
      chk("R9", {29'd0, phy_ready, pll_clk_en, cmd_valid}, 6, "ready hold");
    end else begin
      repeat (3) @(negedge clk);
      chk("R8", {30'd0, pll_clk_en, cmd_valid}, 0, "quiet after fault");
    end
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", {27'd0, pll_clk_en, cmd_valid, phy_ready, seq_err, err_code}, 0, "state in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {27'd0, pll_clk_en, cmd_valid, phy_ready, seq_err, err_code}, 0, "idle after reset");

    for (int k = 0; k < NV; k++) run_vec(k);

    // R1: reset in the middle of a run clears outputs at once
    lat = 3; lock_at = 0; err_at = 0;
    ncmd = 0; nread = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!cmd_valid) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", {28'd0, pll_clk_en, cmd_valid, phy_ready, seq_err}, 0, "async reset mid-run");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {27'd0, pll_clk_en, cmd_valid, phy_ready, seq_err, err_code}, 0, "idle after mid-run reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule